// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps instructions of an out-of-order core in program order between issue and retirement. Each slot records the kind of operation, its destination register, its result, a branch redirect address and an exception marker. The issue stage claims the slot at the tail and receives the slot number as the tag for the result. Execution units then return results out of order through a result port addressed by that tag. Later instructions can read a finished but not yet retired result through a lookup port.

Retirement happens only at the head, one entry per cycle, and only once that entry has its result. Register-writing entries drive a register-file write and store entries drive a store enable. A branch that was found to be mispredicted redirects fetch and empties the buffer. An entry that carries an exception raises it only when it reaches the head, and that also empties the buffer. Depth, data width, register index width, address width and same-cycle lookup forwarding are all parameters.

Top module: `spec_rob`

## Requirements
- R1: `alloc_ready` is low when all DEPTH slots are occupied and the head does not retire in that cycle. Successive allocations get tags 0, 1, 2 and so on, modulo DEPTH, and `alloc_tag` shows the tag of the next allocation.
- R2: A result write to an occupied, unfinished slot marks it finished. From the next cycle, a lookup of that tag shows `lk_ready` high and returns the written value.
- R3: `cm_valid` rises only for the oldest entry and only once its result is present. Entries retire strictly in allocation order, with `cm_dest` and `cm_value` taken from that entry.
- R4: The kind code is 0 for a register write, 1 for a store and 2 for a branch. On retirement, kind 0 raises `cm_reg_we`, kind 1 raises `cm_store_en`, and kind 2 raises neither.
- R5: When the buffer is full and the head retires in the same cycle, an allocation is accepted. It takes the slot the head frees.
- R6: A branch entry written with the mispredict flag raises `flush_valid` for exactly one cycle when it reaches the head, with `flush_pc` equal to its written target. The branch retires, every younger entry is discarded, and the next tag handed out is 0.
- R7: An entry written with the exception flag raises `exc_valid` with `exc_tag` equal to its tag when it reaches the head. It produces no `cm_valid` and no register or store write, the buffer is emptied, and the next tag handed out is 0.
- R8: A result write to a free slot, or to a slot that already holds its result, has no effect. A lookup afterwards shows the slot as not ready or still holding the first value.
- R9: With forwarding enabled (the default), a lookup of the tag being written in the same cycle reports `lk_ready` high and the incoming value.
- R10: After reset the buffer is empty. `alloc_ready` is high, `alloc_tag` is 0, and nothing retires, flushes or raises an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid | input | 1 | Issue requests a slot |
| alloc_kind | input | 2 | Operation kind: 0 register, 1 store, 2 branch |
| alloc_dest | input | REG_W | Destination register of the issued instruction |
| alloc_ready | output | 1 | A slot can be taken this cycle |
| alloc_tag | output | log2(DEPTH) | Tag the next allocation receives |
| wr_valid | input | 1 | Result write strobe |
| wr_tag | input | log2(DEPTH) | Slot the result belongs to |
| wr_value | input | DATA_W | Result value |
| wr_mispredict | input | 1 | Branch turned out mispredicted |
| wr_exception | input | 1 | Instruction raised an exception |
| wr_target | input | PC_W | Correct fetch address for a mispredicted branch |
| lk_tag | input | log2(DEPTH) | Slot to read for an operand |
| lk_ready | output | 1 | Looked-up slot holds a result |
| lk_value | output | DATA_W | Result of the looked-up slot |
| cm_valid | output | 1 | Head entry retires this cycle |
| cm_reg_we | output | 1 | Retiring entry writes the register file |
| cm_store_en | output | 1 | Retiring entry performs its store |
| cm_dest | output | REG_W | Destination of the retiring entry |
| cm_value | output | DATA_W | Result of the retiring entry |
| flush_valid | output | 1 | Mispredict redirect pulse |
| flush_pc | output | PC_W | Redirect address |
| exc_valid | output | 1 | Exception raised by the head entry |
| exc_tag | output | log2(DEPTH) | Tag of the excepting entry |

## Verification
The hardest state to reach from the ports is a full buffer whose head becomes ready in the same cycle that another allocation arrives. Only then does a new entry land in the slot that is being freed. The stimulus fills every slot while holding back results. It then finishes later entries out of order, writes the head last, and offers an allocation in the retiring cycle. Flushes are reached the same way: younger entries are already finished when the mispredicted branch or the excepting entry reaches the head. A long random phase then mixes writes to free, finished and pending slots against a queue-based reference model.

// File: rtl/rob_pkg.sv
package rob_pkg;

   typedef enum logic [1:0] {
      OP_REG    = 2'd0,
      OP_STORE  = 2'd1,
      OP_BRANCH = 2'd2,
      OP_NONE   = 2'd3
   } op_kind_e;

   typedef struct packed {
      logic       busy;
      logic       done;
      logic       exc;
      logic       misp;
      logic [1:0] kind;
   } slot_flags_t;

endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
   parameter int IDX_W = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           inc,
   output logic [IDX_W:0] ptr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   ptr <= '0;
      else if (clr) ptr <= '0;
      else if (inc) ptr <= ptr + 1'b1;
   end
endmodule

// File: rtl/rob_slots.sv
module rob_slots
   import rob_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int IDX_W  = 3,
   parameter int DATA_W = 32,
   parameter int REG_W  = 5,
   parameter int PC_W   = 32,
   parameter bit BYPASS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              alloc_fire,
   input  logic [IDX_W-1:0]  alloc_idx,
   input  logic [1:0]        alloc_kind,
   input  logic [REG_W-1:0]  alloc_dest,
   input  logic              wr_valid,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_value,
   input  logic              wr_misp,
   input  logic              wr_exc,
   input  logic [PC_W-1:0]   wr_target,
   input  logic              commit_fire,
   input  logic [IDX_W-1:0]  head_idx,
   input  logic [IDX_W-1:0]  lk_idx,
   output slot_flags_t       head_flags,
   output logic [REG_W-1:0]  head_dest,
   output logic [DATA_W-1:0] head_value,
   output logic [PC_W-1:0]   head_target,
   output logic              lk_ready,
   output logic [DATA_W-1:0] lk_value
);
   slot_flags_t       flags_q [DEPTH];
   logic [REG_W-1:0]  dest_q  [DEPTH];
   logic [DATA_W-1:0] val_q   [DEPTH];
   logic [PC_W-1:0]   tgt_q   [DEPTH];
   logic [DEPTH-1:0]  wr_hit;

   // a result is taken only by an occupied slot still waiting for it
   always_comb begin
      for (int i = 0; i < DEPTH; i++)
         wr_hit[i] = wr_valid && (wr_idx == IDX_W'(i)) && flags_q[i].busy && !flags_q[i].done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) flags_q[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (flush) begin
               flags_q[i].busy <= 1'b0;
            end else if (alloc_fire && alloc_idx == IDX_W'(i)) begin
               flags_q[i] <= '{busy: 1'b1, done: 1'b0, exc: 1'b0, misp: 1'b0, kind: alloc_kind};
            end else if (wr_hit[i]) begin
               flags_q[i].done <= 1'b1;
               flags_q[i].exc  <= wr_exc;
               flags_q[i].misp <= wr_misp;
            end else if (commit_fire && head_idx == IDX_W'(i)) begin
               flags_q[i].busy <= 1'b0;
            end
         end
      end
   end

   // payload needs no reset: it is only read behind the flags
   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (alloc_fire && alloc_idx == IDX_W'(i)) dest_q[i] <= alloc_dest;
         if (wr_hit[i]) begin
            val_q[i] <= wr_value;
            tgt_q[i] <= wr_target;
         end
      end
   end

   assign head_flags  = flags_q[head_idx];
   assign head_dest   = dest_q[head_idx];
   assign head_value  = val_q[head_idx];
   assign head_target = tgt_q[head_idx];

   generate
      if (BYPASS) begin : g_fwd
         assign lk_ready = (flags_q[lk_idx].busy && flags_q[lk_idx].done) || wr_hit[lk_idx];
         assign lk_value = wr_hit[lk_idx] ? wr_value : val_q[lk_idx];
      end else begin : g_nofwd
         assign lk_ready = flags_q[lk_idx].busy && flags_q[lk_idx].done;
         assign lk_value = val_q[lk_idx];
      end
   endgenerate
endmodule

// File: rtl/rob_retire.sv
module rob_retire
   import rob_pkg::*;
#(
   parameter int IDX_W  = 3,
   parameter int DATA_W = 32,
   parameter int REG_W  = 5,
   parameter int PC_W   = 32
) (
   input  slot_flags_t       head_flags,
   input  logic [IDX_W-1:0]  head_idx,
   input  logic [REG_W-1:0]  head_dest,
   input  logic [DATA_W-1:0] head_value,
   input  logic [PC_W-1:0]   head_target,
   output logic              retire,
   output logic              squash,
   output logic              cm_reg_we,
   output logic              cm_store_en,
   output logic [REG_W-1:0]  cm_dest,
   output logic [DATA_W-1:0] cm_value,
   output logic              flush_valid,
   output logic [PC_W-1:0]   flush_pc,
   output logic              exc_valid,
   output logic [IDX_W-1:0]  exc_tag
);
   logic head_ok;

   always_comb begin
      head_ok     = head_flags.busy && head_flags.done;
      exc_valid   = head_ok && head_flags.exc;
      retire      = head_ok && !head_flags.exc;
      flush_valid = retire && head_flags.misp && (head_flags.kind == OP_BRANCH);
      squash      = exc_valid || flush_valid;
      cm_reg_we   = retire && (head_flags.kind == OP_REG);
      cm_store_en = retire && (head_flags.kind == OP_STORE);
   end

   assign cm_dest  = head_dest;
   assign cm_value = head_value;
   assign flush_pc = head_target;
   assign exc_tag  = head_idx;
endmodule

// File: rtl/spec_rob.sv
module spec_rob
   import rob_pkg::*;
#(
   parameter int DEPTH         = 8,
   parameter int DATA_W        = 32,
   parameter int REG_W         = 5,
   parameter int PC_W          = 32,
   parameter bit LOOKUP_BYPASS = 1'b1,
   localparam int IDX_W        = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic [1:0]        alloc_kind,
   input  logic [REG_W-1:0]  alloc_dest,
   output logic              alloc_ready,
   output logic [IDX_W-1:0]  alloc_tag,
   input  logic              wr_valid,
   input  logic [IDX_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_value,
   input  logic              wr_mispredict,
   input  logic              wr_exception,
   input  logic [PC_W-1:0]   wr_target,
   input  logic [IDX_W-1:0]  lk_tag,
   output logic              lk_ready,
   output logic [DATA_W-1:0] lk_value,
   output logic              cm_valid,
   output logic              cm_reg_we,
   output logic              cm_store_en,
   output logic [REG_W-1:0]  cm_dest,
   output logic [DATA_W-1:0] cm_value,
   output logic              flush_valid,
   output logic [PC_W-1:0]   flush_pc,
   output logic              exc_valid,
   output logic [IDX_W-1:0]  exc_tag
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spec_rob: DEPTH must be a power of two of at least 2");
      end
      if (DATA_W < 1 || REG_W < 1 || PC_W < 1) begin : g_bad_width
         $error("spec_rob: widths must be positive");
      end
   endgenerate

   logic [IDX_W:0]   head_ptr, tail_ptr, occ;
   logic [IDX_W-1:0] head_idx;
   logic             full, retire, squash, alloc_fire;
   slot_flags_t      head_flags;
   logic [REG_W-1:0] head_dest;
   logic [DATA_W-1:0] head_value;
   logic [PC_W-1:0]  head_target;

   assign head_idx    = head_ptr[IDX_W-1:0];
   assign alloc_tag   = tail_ptr[IDX_W-1:0];
   assign occ         = tail_ptr - head_ptr;
   assign full        = (occ == (IDX_W+1)'(DEPTH));
   assign alloc_ready = !squash && (!full || retire);
   assign alloc_fire  = alloc_valid && alloc_ready;
   assign cm_valid    = retire;

   rob_ptr #(.IDX_W(IDX_W)) i_head (
      .clk(clk), .rst_n(rst_n), .clr(squash), .inc(retire), .ptr(head_ptr));

   rob_ptr #(.IDX_W(IDX_W)) i_tail (
      .clk(clk), .rst_n(rst_n), .clr(squash), .inc(alloc_fire), .ptr(tail_ptr));

   rob_slots #(
      .DEPTH(DEPTH), .IDX_W(IDX_W), .DATA_W(DATA_W), .REG_W(REG_W),
      .PC_W(PC_W), .BYPASS(LOOKUP_BYPASS)
   ) i_slots (
      .clk(clk), .rst_n(rst_n), .flush(squash),
      .alloc_fire(alloc_fire), .alloc_idx(alloc_tag),
      .alloc_kind(alloc_kind), .alloc_dest(alloc_dest),
      .wr_valid(wr_valid), .wr_idx(wr_tag), .wr_value(wr_value),
      .wr_misp(wr_mispredict), .wr_exc(wr_exception), .wr_target(wr_target),
      .commit_fire(retire), .head_idx(head_idx), .lk_idx(lk_tag),
      .head_flags(head_flags), .head_dest(head_dest), .head_value(head_value),
      .head_target(head_target), .lk_ready(lk_ready), .lk_value(lk_value));

   rob_retire #(
      .IDX_W(IDX_W), .DATA_W(DATA_W), .REG_W(REG_W), .PC_W(PC_W)
   ) i_retire (
      .head_flags(head_flags), .head_idx(head_idx), .head_dest(head_dest),
      .head_value(head_value), .head_target(head_target),
      .retire(retire), .squash(squash), .cm_reg_we(cm_reg_we),
      .cm_store_en(cm_store_en), .cm_dest(cm_dest), .cm_value(cm_value),
      .flush_valid(flush_valid), .flush_pc(flush_pc),
      .exc_valid(exc_valid), .exc_tag(exc_tag));
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
   parameter int DEPTH = 8,
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_valid,
   input logic             alloc_ready,
   input logic             cm_valid,
   input logic             cm_reg_we,
   input logic             cm_store_en,
   input logic             flush_valid,
   input logic             exc_valid,
   input logic [IDX_W:0]   occ,
   input logic [IDX_W-1:0] head_idx
);
   // R1
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == (IDX_W+1)'(DEPTH) && !cm_valid) |-> !alloc_ready);

   // R3
   head_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cm_valid && !flush_valid) |=> (head_idx == $past(head_idx) + 1'b1));

   // R4
   kind_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cm_reg_we && cm_store_en));

   // R5
   full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == (IDX_W+1)'(DEPTH) && cm_valid && !flush_valid && alloc_valid)
      |=> (occ == (IDX_W+1)'(DEPTH)));

   // R6
   flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |=> (!flush_valid && occ == '0));

   // R7
   exc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (!cm_valid && !cm_reg_we && !cm_store_en));

   // R7
   exc_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |=> (occ == '0));
endmodule

bind spec_rob rob_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_rob_chk (
   .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
   .cm_valid(cm_valid), .cm_reg_we(cm_reg_we), .cm_store_en(cm_store_en),
   .flush_valid(flush_valid), .exc_valid(exc_valid), .occ(occ), .head_idx(head_idx));

// File: tb/test_spec_rob.sv
module test_spec_rob;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 8;
   localparam int IDX_W  = 3;
   localparam int DATA_W = 32;
   localparam int REG_W  = 5;
   localparam int PC_W   = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic alloc_valid = 1'b0;
   logic [1:0] alloc_kind = '0;
   logic [REG_W-1:0] alloc_dest = '0;
   logic alloc_ready;
   logic [IDX_W-1:0] alloc_tag;
   logic wr_valid = 1'b0;
   logic [IDX_W-1:0] wr_tag = '0;
   logic [DATA_W-1:0] wr_value = '0;
   logic wr_mispredict = 1'b0, wr_exception = 1'b0;
   logic [PC_W-1:0] wr_target = '0;
   logic [IDX_W-1:0] lk_tag = '0;
   logic lk_ready;
   logic [DATA_W-1:0] lk_value;
   logic cm_valid, cm_reg_we, cm_store_en;
   logic [REG_W-1:0] cm_dest;
   logic [DATA_W-1:0] cm_value;
   logic flush_valid;
   logic [PC_W-1:0] flush_pc;
   logic exc_valid;
   logic [IDX_W-1:0] exc_tag;

   always #(CLK_PERIOD/2) clk = ~clk;

   spec_rob i_spec_rob (.*);

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;
   string ctx = "";

   // reference model: program-ordered queue of tags plus per-tag records
   int q[$];
   int m_next = 0;
   bit m_done [DEPTH];
   bit m_exc  [DEPTH];
   bit m_misp [DEPTH];
   int m_kind [DEPTH];
   logic [REG_W-1:0]  m_dest [DEPTH];
   logic [DATA_W-1:0] m_val  [DEPTH];
   logic [PC_W-1:0]   m_tgt  [DEPTH];

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s [%s] t=%0t: actual %0h expected %0h", req, ctx, $time, act, exp);
      end
   endtask

   function automatic bit in_q(int t);
      foreach (q[i]) if (q[i] == t) return 1'b1;
      return 1'b0;
   endfunction

   task automatic step(bit av, int ak, int ad, bit wv, int wt, logic [DATA_W-1:0] wval,
                       bit wm, bit we, logic [PC_W-1:0] wtg, int lt);
      bit h_ok, e_exc, e_misp, e_cm, e_fl, e_ar, w_ok, l_ok;
      int h;
      @(negedge clk);
      alloc_valid = av; alloc_kind = 2'(ak); alloc_dest = REG_W'(ad);
      wr_valid = wv; wr_tag = IDX_W'(wt); wr_value = wval;
      wr_mispredict = wm; wr_exception = we; wr_target = wtg; lk_tag = IDX_W'(lt);
      #1;
      h_ok   = (q.size() > 0) && m_done[q[0]];
      h      = h_ok ? q[0] : 0;
      e_exc  = h_ok && m_exc[h];
      e_cm   = h_ok && !m_exc[h];
      e_misp = e_cm && m_kind[h] == 2 && m_misp[h];
      e_fl   = e_exc || e_misp;
      e_ar   = !e_fl && (q.size() < DEPTH || e_cm);
      w_ok   = wv && in_q(wt) && !m_done[wt];
      l_ok   = in_q(lt) && (m_done[lt] || (w_ok && wt == lt));
      chk("R1 alloc_ready", 64'(alloc_ready), 64'(e_ar));
      if (e_ar) chk("R1 alloc_tag", 64'(alloc_tag), 64'(m_next));
      chk("R3 cm_valid", 64'(cm_valid), 64'(e_cm));
      if (e_cm) begin
         chk("R3 cm_dest", 64'(cm_dest), 64'(m_dest[h]));
         chk("R3 cm_value", 64'(cm_value), 64'(m_val[h]));
      end
      chk("R4 cm_reg_we", 64'(cm_reg_we), 64'(e_cm && m_kind[h] == 0));
      chk("R4 cm_store_en", 64'(cm_store_en), 64'(e_cm && m_kind[h] == 1));
      chk("R6 flush_valid", 64'(flush_valid), 64'(e_misp));
      if (e_misp) chk("R6 flush_pc", 64'(flush_pc), 64'(m_tgt[h]));
      chk("R7 exc_valid", 64'(exc_valid), 64'(e_exc));
      if (e_exc) chk("R7 exc_tag", 64'(exc_tag), 64'(h));
      chk((w_ok && wt == lt) ? "R9 lk_ready" : "R2 lk_ready", 64'(lk_ready), 64'(l_ok));
      if (l_ok) chk((w_ok && wt == lt) ? "R9 lk_value" : "R2 lk_value", 64'(lk_value),
                    64'((w_ok && wt == lt) ? wval : m_val[lt]));
      @(posedge clk);
      if (e_fl) begin
         q.delete();
         m_next = 0;
      end else begin
         if (w_ok) begin
            m_done[wt] = 1'b1; m_val[wt] = wval; m_misp[wt] = wm;
            m_exc[wt] = we; m_tgt[wt] = wtg;
         end
         if (e_cm) void'(q.pop_front());
         if (av && e_ar) begin
            q.push_back(m_next);
            m_done[m_next] = 1'b0; m_kind[m_next] = ak; m_dest[m_next] = REG_W'(ad);
            m_next = (m_next + 1) % DEPTH;
         end
      end
   endtask

   task automatic idle(int lt);
      step(0, 0, 0, 0, 0, '0, 0, 0, '0, lt);
   endtask

   task automatic alloc(int k, int d);
      step(1, k, d, 0, 0, '0, 0, 0, '0, 0);
   endtask

   task automatic wr(int t, logic [DATA_W-1:0] v, bit m, bit e, logic [PC_W-1:0] tg, int lt);
      step(0, 0, 0, 1, t, v, m, e, tg, lt);
   endtask

   initial begin
      int b;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      ctx = "R10 reset"; idle(0);

      ctx = "R1 fill";
      for (int i = 0; i < DEPTH; i++) alloc(0, i + 1);
      alloc(0, 20);

      ctx = "R2 out-of-order write";
      wr(5, 32'h55, 0, 0, '0, 0);
      wr(3, 32'h33, 0, 0, '0, 5);
      ctx = "R9 same-cycle lookup";
      wr(6, 32'h66, 0, 0, '0, 6);

      ctx = "R5 full retire and allocate";
      wr(0, 32'h100, 0, 0, '0, 0);
      alloc(0, 9);
      alloc(0, 10);

      ctx = "R8 rewrite of finished slot";
      wr(5, 32'hBAD, 0, 0, '0, 5);
      idle(5);

      ctx = "R3 in-order drain";
      wr(2, 32'h22, 0, 0, '0, 1);
      wr(1, 32'h11, 0, 0, '0, 2);
      wr(4, 32'h44, 0, 0, '0, 4);
      wr(7, 32'h77, 0, 0, '0, 0);
      wr(0, 32'h900, 0, 0, '0, 7);
      repeat (10) idle(0);

      ctx = "R8 write to free slot";
      wr(3, 32'hF3, 0, 0, '0, 3);
      idle(3);

      ctx = "R4 store and branch";
      b = m_next;
      alloc(1, 2);
      alloc(2, 0);
      wr((b + 1) % DEPTH, 32'h0, 0, 0, 32'h1234, 0);
      wr(b, 32'hCAFE, 0, 0, '0, 0);
      repeat (3) idle(0);

      ctx = "R6 mispredict";
      b = m_next;
      alloc(2, 0);
      alloc(0, 4);
      alloc(0, 5);
      wr((b + 1) % DEPTH, 32'hA1, 0, 0, '0, 0);
      wr((b + 2) % DEPTH, 32'hA2, 0, 0, '0, (b + 1) % DEPTH);
      wr(b, 32'h0, 1, 0, 32'h4000, 0);
      idle((b + 1) % DEPTH);
      idle((b + 2) % DEPTH);
      alloc(0, 6);
      repeat (2) idle(0);
      wr(0, 32'h60, 0, 0, '0, 0);
      repeat (2) idle(0);

      ctx = "R7 exception";
      b = m_next;
      alloc(0, 7);
      alloc(1, 8);
      alloc(0, 9);
      wr((b + 1) % DEPTH, 32'hEE, 0, 1, '0, 0);
      wr((b + 2) % DEPTH, 32'hE2, 0, 0, '0, 0);
      wr(b, 32'h70, 0, 0, '0, 0);
      repeat (3) idle((b + 2) % DEPTH);
      alloc(0, 3);

      ctx = "random";
      for (int n = 0; n < 4000; n++) begin
         bit av, wv, wm, we;
         int wt;
         av = ($urandom % 2) == 0;
         wv = ($urandom % 5) < 3;
         if (q.size() > 0 && ($urandom % 8) != 0) wt = q[$urandom % q.size()];
         else wt = $urandom % DEPTH;
         wm = ($urandom % 5) == 0;
         we = ($urandom % 20) == 0;
         step(av, $urandom % 3, $urandom % 32, wv, wt, $urandom, wm, we, $urandom,
              $urandom % DEPTH);
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule